// File: doc/BRIEF.md
# Interrupt Status and Clear Unit

This block gathers twelve event sources of a serial bus controller into one raw status register, filters it through a software-written enable mask and raises a single interrupt line whenever any enabled bit is set. Ten sources are sticky: a one-cycle pulse sets the bit, and it holds until software clears it. Two sources, the receive-threshold and transmit-threshold conditions, are level driven and simply track their inputs.

Software clears sticky bits by reading. Each sticky source has its own clear address, and a single combined-clear address wipes all of them in one access. A separate register collects the reasons for a transmit abort. Cause bits are OR-ed in on every abort pulse, and reading the abort clear address (or the combined clear) wipes them together with the abort status bit. Reads are a simple enable-plus-address port with a combinational data return, and any clear takes effect at the clock edge that ends the read.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the raw status, the mask, the masked status and the abort-cause register all read zero and `irq_o` is low.
- R2: Raw status (address 0x34) uses bit positions rx_under 0, rx_over 1, rx_full 2, tx_over 3, tx_empty 4, rd_req 5, tx_abrt 6, rx_done 7, activity 8, stop_det 9, start_det 10, gen_call 11. A pulse on `evt_i[n]` of a sticky source sets bit n at the next clock edge, and the bit stays set until it is cleared.
- R3: The mask is written through `mask_we_i` and reads back at 0x30. Masked status at 0x2C equals raw AND mask, and `irq_o` is high exactly when the masked status is non-zero.
- R4: Raw bits 2 and 4 copy `rx_full_lvl_i` and `tx_empty_lvl_i` one cycle later. Pulses on `evt_i[2]` and `evt_i[4]` have no effect, and no clear read changes these two bits.
- R5: Reading a single-source clear address returns that raw bit in data bit 0 and clears the bit. The addresses run from 0x44 upward in steps of 4 over the sticky sources in bit order, skipping the two level sources: rx_under 0x44, rx_over 0x48, tx_over 0x4C, rd_req 0x50, tx_abrt 0x54, rx_done 0x58, activity 0x5C, stop_det 0x60, start_det 0x64, gen_call 0x68.
- R6: Reading 0x40 clears every sticky bit and the abort-cause register.
- R7: An event pulse in the same cycle as a read that clears its bit leaves the bit set.
- R8: The abort-cause register, read at 0x80, ORs in `abrt_cause_i` on each cycle in which `evt_i[6]` pulses. Its bits are: 7-bit address nack 0, 10-bit first address byte nack 1, 10-bit second address byte nack 2, data nack 3, general-call nack 4, general-call read 5, start byte acknowledged 7, start byte with restart off 9, 10-bit read with restart off 10, master disabled 11, arbitration lost 12. Bits 6 and 8 always read zero.
- R9: Reading 0x54 wipes the abort-cause register. If a new abort pulses in that same cycle, the register holds only the new cause afterwards.
- R10: A read of any other address returns zero and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 12 | One-cycle event pulses, one per status bit |
| rx_full_lvl_i | input | 1 | Receive threshold level |
| tx_empty_lvl_i | input | 1 | Transmit threshold level |
| abrt_cause_i | input | 13 | Abort reasons, sampled with evt_i[6] |
| mask_we_i | input | 1 | Mask write enable |
| mask_wdata_i | input | 12 | Mask write data |
| rd_en_i | input | 1 | Read strobe; clear reads act at the clock edge |
| rd_addr_i | input | 8 | Read byte address |
| rd_data_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situations to create are the collisions: an event pulse and its own clear read landing in the same cycle, and a fresh abort arriving just as the abort-cause register is being wiped. Both need the pulse and the read strobe driven in one cycle. The bench does this from a directed task that raises both before the same edge, then reads the status and cause back. Ignored inputs (event pulses on the level bits, reserved cause bits, clear reads aimed at level bits) are checked by reading the affected register right afterwards.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int NUM_SRC = 12;
  localparam int CAUSE_W = 13;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;

  localparam int SRC_RX_FULL  = 2;
  localparam int SRC_TX_EMPTY = 4;
  localparam int SRC_TX_ABRT  = 6;

  // sources that follow a level instead of latching a pulse
  localparam logic [NUM_SRC-1:0] LVL_SRC     = 12'h014;
  localparam logic [CAUSE_W-1:0] CAUSE_VALID = 13'h1EBF;

  localparam logic [ADDR_W-1:0] A_STAT     = 8'h2C;
  localparam logic [ADDR_W-1:0] A_MASK     = 8'h30;
  localparam logic [ADDR_W-1:0] A_RAW      = 8'h34;
  localparam logic [ADDR_W-1:0] A_CLR_ALL  = 8'h40;
  localparam logic [ADDR_W-1:0] A_CLR_BASE = 8'h44;
  localparam logic [ADDR_W-1:0] A_CAUSE    = 8'h80;

  // clear addresses are packed over sticky sources only
  function automatic logic [ADDR_W-1:0] clr_addr(int idx);
    int n;
    n = 0;
    for (int j = 0; j < idx; j++) if (!LVL_SRC[j]) n++;
    return A_CLR_BASE + ADDR_W'(4 * n);
  endfunction
endpackage

// File: rtl/irq_src_bit.sv
module irq_src_bit #(
  parameter bit LEVEL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic clr_i,
  output logic bit_o
);
  logic bit_q;

  if (LEVEL) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= src_i;

    AST_LVL_NO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i && src_i |=> bit_q); // R4
  end else begin : g_stk
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= src_i | (bit_q & ~clr_i);

    AST_STK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_i |=> bit_q); // R7
    AST_STK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i && !src_i |=> !bit_q); // R5
    AST_STK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_q && !clr_i |=> bit_q); // R2
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/irq_clr_dec.sv
module irq_clr_dec import irq_stat_pkg::*; (
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [NUM_SRC-1:0] clr_o,
  output logic              clr_all_o
);
  logic [NUM_SRC-1:0] hit_one;

  assign clr_all_o = rd_en_i && (rd_addr_i == A_CLR_ALL);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_dec
    if (LVL_SRC[i]) begin : g_none
      assign hit_one[i] = 1'b0;
    end else begin : g_hit
      assign hit_one[i] = (rd_addr_i == clr_addr(i));
    end
    assign clr_o[i] = rd_en_i & (hit_one[i] | clr_all_o);
  end

  always_comb begin
    AST_DEC_ONE: assert ($onehot0(hit_one)); // R5
  end
endmodule

// File: rtl/irq_abrt_cause.sv
module irq_abrt_cause import irq_stat_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               abrt_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               clr_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [CAUSE_W-1:0] cause_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cause_q <= '0;
    else cause_q <= (clr_i ? '0 : cause_q) | (abrt_i ? (cause_i & CAUSE_VALID) : '0);

  assign cause_o = cause_q;

  AST_CAUSE_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_q & ~CAUSE_VALID) == '0); // R8
  AST_CAUSE_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cause_q & $past(cause_q)) == $past(cause_q)); // R8
  AST_CAUSE_WIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !abrt_i |=> cause_q == '0); // R9
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit import irq_stat_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               rx_full_lvl_i,
  input  logic               tx_empty_lvl_i,
  input  logic [CAUSE_W-1:0] abrt_cause_i,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_wdata_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] src, clr, raw, mask_q, stat;
  logic [CAUSE_W-1:0] cause;
  logic               clr_all;

  irq_clr_dec u_dec (
    .rd_en_i  (rd_en_i),
    .rd_addr_i(rd_addr_i),
    .clr_o    (clr),
    .clr_all_o(clr_all)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i == SRC_RX_FULL) begin : g_rxf
      assign src[i] = rx_full_lvl_i;
    end else if (i == SRC_TX_EMPTY) begin : g_txe
      assign src[i] = tx_empty_lvl_i;
    end else begin : g_evt
      assign src[i] = evt_i[i];
    end
    irq_src_bit #(.LEVEL(LVL_SRC[i])) u_bit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .src_i (src[i]),
      .clr_i (clr[i]),
      .bit_o (raw[i])
    );
  end

  irq_abrt_cause u_cause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .abrt_i (evt_i[SRC_TX_ABRT]),
    .cause_i(abrt_cause_i),
    .clr_i  (clr[SRC_TX_ABRT]),
    .cause_o(cause)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;

  assign stat  = raw & mask_q;
  assign irq_o = |stat;

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      unique case (rd_addr_i)
        A_STAT:  rd_data_o = DATA_W'(stat);
        A_MASK:  rd_data_o = DATA_W'(mask_q);
        A_RAW:   rd_data_o = DATA_W'(raw);
        A_CAUSE: rd_data_o = DATA_W'(cause);
        default: begin
          for (int i = 0; i < NUM_SRC; i++)
            if (!LVL_SRC[i] && rd_addr_i == clr_addr(i)) rd_data_o = DATA_W'(raw[i]);
        end
      endcase
    end
  end

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw == '0 |-> !irq_o); // R3
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q == '0 |-> !irq_o); // R3
  AST_RXF_PULSE_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[SRC_RX_FULL] && !rx_full_lvl_i |=> !raw[SRC_RX_FULL]); // R4
  AST_TXE_PULSE_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[SRC_TX_EMPTY] && !tx_empty_lvl_i |=> !raw[SRC_TX_EMPTY]); // R4
  AST_CLR_ALL_WIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all && evt_i == '0 |=> (raw & ~LVL_SRC) == '0); // R6
endmodule

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] evt_i = '0;
  logic        rx_full_lvl_i = 1'b0;
  logic        tx_empty_lvl_i = 1'b0;
  logic [12:0] abrt_cause_i = '0;
  logic        mask_we_i = 1'b0;
  logic [11:0] mask_wdata_i = '0;
  logic        rd_en_i = 1'b0;
  logic [7:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  irq_status_unit dut (.*);

  always #5 clk_i = ~clk_i;

  // {evt, mask, expected raw, expected status, expected irq}
  localparam int NV = 6;
  localparam logic [48:0] VEC [NV] = '{
    {12'h001, 12'hFFF, 12'h001, 12'h001, 1'b1},
    {12'h800, 12'h7FF, 12'h800, 12'h000, 1'b0},
    {12'hA40, 12'h040, 12'hA40, 12'h040, 1'b1},
    {12'h014, 12'hFFF, 12'h000, 12'h000, 1'b0},
    {12'hFFF, 12'h000, 12'hFEB, 12'h000, 1'b0},
    {12'h30A, 12'h108, 12'h30A, 12'h108, 1'b1}
  };

  task automatic cyc();
    @(posedge clk_i);
    #2;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    rd_en_i = 1'b1;
    rd_addr_i = a;
    #1;
    d = rd_data_o;
    cyc();
    rd_en_i = 1'b0;
    rd_addr_i = '0;
  endtask

  task automatic pulse(logic [11:0] e, logic [12:0] c);
    evt_i = e;
    abrt_cause_i = c;
    cyc();
    evt_i = '0;
    abrt_cause_i = '0;
  endtask

  task automatic wr_mask(logic [11:0] m);
    mask_we_i = 1'b1;
    mask_wdata_i = m;
    cyc();
    mask_we_i = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    cyc();

    // R1 reset state
    rd(8'h34, d); chk("R1 raw", d, 0);
    rd(8'h30, d); chk("R1 mask", d, 0);
    rd(8'h2C, d); chk("R1 status", d, 0);
    rd(8'h80, d); chk("R1 cause", d, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);

    // R2 R3 R4 table
    for (int v = 0; v < NV; v++) begin
      rd(8'h40, d);
      wr_mask(VEC[v][36:25]);
      pulse(VEC[v][48:37], 13'h0);
      rd(8'h34, d); chk("R2 raw vector", d, {20'b0, VEC[v][24:13]});
      rd(8'h2C, d); chk("R3 status vector", d, {20'b0, VEC[v][12:1]});
      rd(8'h30, d); chk("R3 mask readback", d, {20'b0, VEC[v][36:25]});
      chk("R3 irq vector", {31'b0, irq_o}, {31'b0, VEC[v][0]});
    end

    // R4 level sources
    rd(8'h40, d);
    wr_mask(12'hFFF);
    rx_full_lvl_i = 1'b1;
    cyc();
    rd(8'h34, d); chk("R4 rx_full follows", d, 32'h004);
    chk("R4 irq from level", {31'b0, irq_o}, 1);
    rd(8'h40, d);
    rd(8'h34, d); chk("R4 clear-all keeps level", d, 32'h004);
    rx_full_lvl_i = 1'b0;
    tx_empty_lvl_i = 1'b1;
    cyc();
    rd(8'h34, d); chk("R4 tx_empty follows", d, 32'h010);
    tx_empty_lvl_i = 1'b0;
    cyc();
    rd(8'h34, d); chk("R4 level drops", d, 0);

    // R5 single clears
    pulse(12'h208, 13'h0);
    rd(8'h4C, d); chk("R5 tx_over clear returns bit", d, 1);
    rd(8'h34, d); chk("R5 tx_over cleared only", d, 32'h200);
    rd(8'h60, d); chk("R5 stop_det clear returns bit", d, 1);
    rd(8'h34, d); chk("R5 stop_det cleared", d, 0);
    rd(8'h60, d); chk("R5 clear of idle bit returns 0", d, 0);
    pulse(12'h800, 13'h0);
    rd(8'h68, d); chk("R5 gen_call clear", d, 1);
    rd(8'h34, d); chk("R5 gen_call cleared", d, 0);

    // R7 collision
    pulse(12'h080, 13'h0);
    evt_i = 12'h080;
    rd(8'h58, d);
    evt_i = '0;
    rd(8'h34, d); chk("R7 set wins over clear", d, 32'h080);
    rd(8'h58, d);
    rd(8'h34, d); chk("R7 later clear works", d, 0);

    // R8 abort cause accumulation
    pulse(12'h040, 13'h0001);
    pulse(12'h040, 13'h1000);
    rd(8'h80, d); chk("R8 cause accumulates", d, 32'h1001);
    pulse(12'h040, 13'h0140);
    rd(8'h80, d); chk("R8 reserved cause bits", d, 32'h1001);
    pulse(12'h000, 13'h0008);
    rd(8'h80, d); chk("R8 cause needs abort pulse", d, 32'h1001);

    // R9 abort clear
    rd(8'h54, d); chk("R9 abort clear returns bit", d, 1);
    rd(8'h80, d); chk("R9 cause wiped", d, 0);
    rd(8'h34, d); chk("R9 abort bit cleared", d, 0);
    pulse(12'h040, 13'h0001);
    evt_i = 12'h040;
    abrt_cause_i = 13'h0008;
    rd(8'h54, d);
    evt_i = '0;
    abrt_cause_i = '0;
    rd(8'h80, d); chk("R9 new cause on wipe", d, 32'h0008);
    rd(8'h34, d); chk("R9 abort bit kept", d, 32'h040);

    // R6 combined clear
    pulse(12'hFFF, 13'h1EBF);
    rd(8'h40, d); chk("R6 clear-all returns 0", d, 0);
    rd(8'h34, d); chk("R6 all sticky cleared", d, 0);
    rd(8'h80, d); chk("R6 cause cleared", d, 0);

    // R10 unmapped address
    pulse(12'h002, 13'h0);
    rd(8'h00, d); chk("R10 unmapped reads 0", d, 0);
    rd(8'h6C, d); chk("R10 past last clear reads 0", d, 0);
    rd(8'h34, d); chk("R10 no side effect", d, 32'h002);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule